// File: doc/BRIEF.md
# Video processor control register slave on I2C

This block sits behind a two-wire serial bus and holds twenty byte-wide control registers that steer a television video processor (source selection, geometry, white point, picture controls and so on). A host writes the device address 0x8A, then a register index, then any number of data bytes; each data byte lands at the current index and the index moves up by one. Bytes aimed at an index with no register behind it, including the index kept back for factory test, are acknowledged and then dropped.

Reading with address 0x8B returns two status bytes. The first carries a sticky power-up flag that is set by reset or by a supply dip and clears once a byte carrying it has been clocked out to the host. The second carries a missing-deflection flag and an IF signal-present flag taken straight from inputs. The block also raises a ready flag once every register has been written since the power-up flag last cleared, so that downstream logic knows it may start calibrating the line oscillator.

The serial lines are brought into the clock domain through two flip-flops each; the slave never stretches the clock and answers only its own 7-bit address.

Top module: `vidctl_i2c_regs`

## Requirements
- R1: The slave acknowledges the address bytes 0x8A (write) and 0x8B (read), i.e. 7-bit address 0x45; any other address byte gets no acknowledge and leaves every register unchanged.
- R2: In a write, the first byte after the address is taken as the register index and each later byte is stored in register `index`, visible on `ctrl_regs_o[8*index+7 : 8*index]`; every byte is acknowledged.
- R3: After each data byte the index rises by one while it is below 0x13; at 0x13 it holds, so further bytes in the same burst overwrite register 0x13.
- R4: A data byte sent while the index is 0x14 to 0xFF (the test index 0xFE included) is acknowledged, changes no register, and leaves the index where it is.
- R5: A read returns first {POR, 7'b0}, then {no_defl_i, 2'b0, if_ident_i, 4'b0}, then 0x00 for any further byte; the host's NACK ends the read.
- R6: POR is 1 after reset and after any cycle with `brownout` high; it clears once the first status byte carrying it has been fully shifted out, unless `brownout` is high at any time during that byte, in which case it stays 1.
- R7: `all_written_o` is 1 exactly when all twenty registers have been written since POR last went to 0; it is 0 while POR is 1, and writes made while POR is 1 do not count.
- R8: After reset the registers read 0x00, `sda_oe` is 0 and `all_written_o` is 0.
- R9: The slave starts pulling SDA low only while SCL is low.
- R10: A repeated START in the middle of a transfer restarts address reception, and a STOP returns the slave to idle; data already stored is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| brownout | input | 1 | Supply dip indication, sets POR |
| no_defl_i | input | 1 | Missing-deflection flag for status byte 1 |
| if_ident_i | input | 1 | IF signal-present flag for status byte 1 |
| ctrl_regs_o | output | 160 | Twenty control registers, register k in bits 8k+7..8k |
| all_written_o | output | 1 | Every register written since POR cleared |

## Verification
The two functions that can meet in one cycle are the clearing of POR at the end of the status byte that carried it and the setting of POR by a supply dip. The bench provokes this by holding `brownout` high across the whole first status byte of a read, so the dip covers the cycle in which the byte finishes, and judges it by reading the status again: the first byte must still be 0x80, and only the read after that may clear it. A second overlap, a register write landing while POR is set, is judged by `all_written_o` staying low after a full burst made before the host has polled POR.

// File: rtl/vidctl_pkg.sv
package vidctl_pkg;

    localparam int          CTRL_REGS  = 20;
    localparam logic [6:0]  DEV_ADDR   = 7'h45;
    localparam int          SYNC_DEPTH = 2;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_AACK,
        PH_WRITE,
        PH_WACK,
        PH_READ,
        PH_RACK
    } phase_e;

    typedef struct packed {
        logic       start;
        logic       stop;
        logic       rise;
        logic       fall;
        logic       sda;
    } bus_ev_t;

    typedef struct packed {
        logic       valid;
        logic       is_sub;
        logic [7:0] data;
    } wr_strobe_t;

    function automatic logic idx_below(input logic [7:0] idx, input int limit);
        return int'(idx) < limit;
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import vidctl_pkg::*;
#(
    parameter int STAGES = SYNC_DEPTH
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_t ev,
    output logic    scl_o
);

    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_d;
    logic              sda_d;
    logic              scl_now;
    logic              sda_now;

    assign scl_now = scl_ff[STAGES-1];
    assign sda_now = sda_ff[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_in};
            sda_ff <= {sda_ff[STAGES-2:0], sda_in};
            scl_d  <= scl_now;
            sda_d  <= sda_now;
        end
    end

    always_comb begin
        ev.start = scl_now & scl_d & sda_d & ~sda_now;
        ev.stop  = scl_now & scl_d & ~sda_d & sda_now;
        ev.rise  = scl_now & ~scl_d;
        ev.fall  = ~scl_now & scl_d;
        ev.sda   = sda_now;
    end

    assign scl_o = scl_now;

endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
    import vidctl_pkg::*;
#(
    parameter logic [6:0] ADDR = DEV_ADDR
) (
    input  logic       clk,
    input  logic       rst,
    input  bus_ev_t    ev,
    input  logic [7:0] tx_byte,
    output logic       sda_oe,
    output wr_strobe_t wr,
    output logic       rd_begin,
    output logic       tx_load,
    output logic       tx_done
);

    phase_e     phase;
    logic [7:0] shreg;
    logic [7:0] txreg;
    logic [3:0] bitcnt;
    logic       rnw;
    logic       first;
    logic       nack;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            shreg    <= '0;
            txreg    <= '0;
            bitcnt   <= '0;
            rnw      <= 1'b0;
            first    <= 1'b0;
            nack     <= 1'b1;
            sda_oe   <= 1'b0;
            wr       <= '0;
            rd_begin <= 1'b0;
            tx_load  <= 1'b0;
            tx_done  <= 1'b0;
        end else begin
            wr.valid <= 1'b0;
            rd_begin <= 1'b0;
            tx_load  <= 1'b0;
            tx_done  <= 1'b0;
            if (ev.start) begin
                phase  <= PH_ADDR;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else if (ev.stop) begin
                phase  <= PH_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (phase)
                    PH_ADDR, PH_WRITE: begin
                        if (ev.rise && bitcnt != 4'd8) begin
                            shreg  <= {shreg[6:0], ev.sda};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (ev.fall && bitcnt == 4'd8) begin
                            bitcnt <= '0;
                            if (phase == PH_ADDR) begin
                                if (shreg[7:1] == ADDR) begin
                                    phase    <= PH_AACK;
                                    sda_oe   <= 1'b1;
                                    rnw      <= shreg[0];
                                    rd_begin <= shreg[0];
                                end else begin
                                    phase <= PH_IDLE;
                                end
                            end else begin
                                phase     <= PH_WACK;
                                sda_oe    <= 1'b1;
                                wr.valid  <= 1'b1;
                                wr.is_sub <= first;
                                wr.data   <= shreg;
                                first     <= 1'b0;
                            end
                        end
                    end
                    PH_AACK: begin
                        if (ev.fall) begin
                            if (rnw) begin
                                phase   <= PH_READ;
                                txreg   <= tx_byte;
                                sda_oe  <= ~tx_byte[7];
                                bitcnt  <= 4'd1;
                                tx_load <= 1'b1;
                            end else begin
                                phase  <= PH_WRITE;
                                sda_oe <= 1'b0;
                                first  <= 1'b1;
                            end
                        end
                    end
                    PH_WACK: begin
                        if (ev.fall) begin
                            phase  <= PH_WRITE;
                            sda_oe <= 1'b0;
                        end
                    end
                    PH_READ: begin
                        if (ev.fall) begin
                            if (bitcnt == 4'd8) begin
                                phase   <= PH_RACK;
                                sda_oe  <= 1'b0;
                                tx_done <= 1'b1;
                            end else begin
                                sda_oe <= ~txreg[6];
                                txreg  <= {txreg[6:0], 1'b0};
                                bitcnt <= bitcnt + 4'd1;
                            end
                        end
                    end
                    PH_RACK: begin
                        if (ev.rise) begin
                            nack <= ev.sda;
                        end else if (ev.fall) begin
                            if (!nack) begin
                                phase   <= PH_READ;
                                txreg   <= tx_byte;
                                sda_oe  <= ~tx_byte[7];
                                bitcnt  <= 4'd1;
                                tx_load <= 1'b1;
                            end else begin
                                phase <= PH_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/ctrl_reg_bank.sv
module ctrl_reg_bank
    import vidctl_pkg::*;
#(
    parameter int N = CTRL_REGS
) (
    input  logic           clk,
    input  logic           rst,
    input  wr_strobe_t     wr,
    input  logic           por,
    output logic [N*8-1:0] regs_o,
    output logic [7:0]     ptr_o,
    output logic           all_written
);

    localparam int LAST = N - 1;

    logic [7:0]   ptr;
    logic [7:0]   mem [N];
    logic [N-1:0] hit;
    logic [N-1:0] seen;
    logic         data_wr;

    assign data_wr = wr.valid & ~wr.is_sub;

    for (genvar i = 0; i < N; i++) begin : g_slot
        assign hit[i]            = data_wr && (ptr == 8'(i));
        assign regs_o[8*i +: 8]  = mem[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) mem[i] <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (hit[i]) mem[i] <= wr.data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || por) begin
            seen <= '0;
        end else begin
            seen <= seen | hit;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (wr.valid) begin
            if (wr.is_sub) begin
                ptr <= wr.data;
            end else if (idx_below(ptr, LAST)) begin
                ptr <= ptr + 8'd1;
            end
        end
    end

    assign ptr_o       = ptr;
    assign all_written = (&seen) & ~por;

endmodule

// File: rtl/status_reply.sv
module status_reply (
    input  logic       clk,
    input  logic       rst,
    input  logic       brownout,
    input  logic       no_defl,
    input  logic       if_ident,
    input  logic       rd_begin,
    input  logic       tx_load,
    input  logic       tx_done,
    output logic       por,
    output logic [7:0] tx_byte
);

    logic [1:0] idx;
    logic       carried;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
        end else if (rd_begin) begin
            idx <= '0;
        end else if (tx_load && idx != 2'd2) begin
            idx <= idx + 2'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            por     <= 1'b1;
            carried <= 1'b0;
        end else if (brownout) begin
            por     <= 1'b1;
            carried <= 1'b0;
        end else if (rd_begin) begin
            carried <= 1'b0;
        end else if (tx_load) begin
            carried <= (idx == 2'd0) && por;
        end else if (tx_done && carried) begin
            por     <= 1'b0;
            carried <= 1'b0;
        end
    end

    always_comb begin
        case (idx)
            2'd0:    tx_byte = {por, 7'b0};
            2'd1:    tx_byte = {no_defl, 2'b0, if_ident, 4'b0};
            default: tx_byte = 8'h00;
        endcase
    end

endmodule

// File: rtl/vidctl_i2c_regs.sv
module vidctl_i2c_regs
    import vidctl_pkg::*;
#(
    parameter int         NUM_REGS = CTRL_REGS,
    parameter int         SYNC_FF  = SYNC_DEPTH,
    parameter logic [6:0] SLV_ADDR = DEV_ADDR
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  scl_in,
    input  logic                  sda_in,
    output logic                  sda_oe,
    input  logic                  brownout,
    input  logic                  no_defl_i,
    input  logic                  if_ident_i,
    output logic [NUM_REGS*8-1:0] ctrl_regs_o,
    output logic                  all_written_o
);

    bus_ev_t    bus_ev;
    logic       scl_lvl;
    wr_strobe_t wr_stb;
    logic       rd_begin;
    logic       tx_load;
    logic       tx_done;
    logic [7:0] tx_byte;
    logic       por_flag;
    logic [7:0] wr_ptr;

    i2c_line_sync #(.STAGES(SYNC_FF)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (bus_ev),
        .scl_o  (scl_lvl)
    );

    i2c_slave_fsm #(.ADDR(SLV_ADDR)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .ev       (bus_ev),
        .tx_byte  (tx_byte),
        .sda_oe   (sda_oe),
        .wr       (wr_stb),
        .rd_begin (rd_begin),
        .tx_load  (tx_load),
        .tx_done  (tx_done)
    );

    ctrl_reg_bank #(.N(NUM_REGS)) u_bank (
        .clk         (clk),
        .rst         (rst),
        .wr          (wr_stb),
        .por         (por_flag),
        .regs_o      (ctrl_regs_o),
        .ptr_o       (wr_ptr),
        .all_written (all_written_o)
    );

    status_reply u_stat (
        .clk      (clk),
        .rst      (rst),
        .brownout (brownout),
        .no_defl  (no_defl_i),
        .if_ident (if_ident_i),
        .rd_begin (rd_begin),
        .tx_load  (tx_load),
        .tx_done  (tx_done),
        .por      (por_flag),
        .tx_byte  (tx_byte)
    );

endmodule

// File: rtl/vidctl_i2c_regs_chk.sv
module vidctl_i2c_regs_chk
    import vidctl_pkg::*;
#(
    parameter int N = CTRL_REGS
) (
    input logic           clk,
    input logic           rst,
    input logic           brownout,
    input logic           por_flag,
    input logic           all_written_o,
    input logic           sda_oe,
    input logic           scl_lvl,
    input logic           tx_done,
    input wr_strobe_t     wr_stb,
    input logic [7:0]     wr_ptr,
    input logic [N*8-1:0] ctrl_regs_o
);

    assert_por_set_R6: assert property (@(posedge clk) disable iff (rst)
        brownout |=> por_flag);

    assert_por_clear_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(por_flag) |-> $past(tx_done));

    assert_flag_drop_R7: assert property (@(posedge clk) disable iff (rst)
        brownout |=> !all_written_o);

    assert_sda_scl_low_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !$past(scl_lvl));

    assert_discard_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_stb.valid && !wr_stb.is_sub && !idx_below(wr_ptr, N)) |=> $stable(ctrl_regs_o));

endmodule

bind vidctl_i2c_regs vidctl_i2c_regs_chk #(.N(NUM_REGS)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .brownout      (brownout),
    .por_flag      (por_flag),
    .all_written_o (all_written_o),
    .sda_oe        (sda_oe),
    .scl_lvl       (scl_lvl),
    .tx_done       (tx_done),
    .wr_stb        (wr_stb),
    .wr_ptr        (wr_ptr),
    .ctrl_regs_o   (ctrl_regs_o)
);

// File: tb/vidctl_i2c_regs_test.sv
module vidctl_i2c_regs_test;

    localparam int NR = 20;
    localparam int Q  = 8;

    typedef struct packed {
        logic [7:0] sub;
        logic [1:0] n;
        logic [7:0] d0;
        logic [7:0] d1;
        logic [7:0] d2;
        logic [7:0] csub;
        logic [7:0] cval;
        logic       keep;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{8'h00, 2'd1, 8'h11, 8'h00, 8'h00, 8'h00, 8'h11, 1'b0},
        '{8'h05, 2'd3, 8'h21, 8'h22, 8'h23, 8'h07, 8'h23, 1'b0},
        '{8'h12, 2'd3, 8'h31, 8'h32, 8'h33, 8'h13, 8'h33, 1'b0},
        '{8'h12, 2'd1, 8'h41, 8'h00, 8'h00, 8'h12, 8'h41, 1'b0},
        '{8'hFE, 2'd1, 8'h5A, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1},
        '{8'h14, 2'd2, 8'h66, 8'h67, 8'h00, 8'h00, 8'h00, 1'b1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic brownout = 1'b0;
    logic no_defl_i = 1'b0;
    logic if_ident_i = 1'b0;
    logic sda_oe;
    logic sda_line;
    logic [NR*8-1:0] ctrl_regs_o;
    logic all_written_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0] exp_r [NR];
    logic [7:0] wbuf [24];
    logic [7:0] rbuf [4];
    logic [NR*8-1:0] snap;

    always #4 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    vidctl_i2c_regs uut (
        .clk           (clk),
        .rst           (rst),
        .scl_in        (scl_m),
        .sda_in        (sda_line),
        .sda_oe        (sda_oe),
        .brownout      (brownout),
        .no_defl_i     (no_defl_i),
        .if_ident_i    (if_ident_i),
        .ctrl_regs_o   (ctrl_regs_o),
        .all_written_o (all_written_o)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag, input logic [159:0] act, input logic [159:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic put_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q);
            scl_m = 1'b1; tick(2*Q);
            scl_m = 1'b0; tick(Q);
        end
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        ack = !sda_line; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic get_byte(input bit last, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            scl_m = 1'b1; tick(Q);
            b[i] = sda_line; tick(Q);
            scl_m = 1'b0; tick(Q);
        end
        sda_m = last; tick(Q);
        scl_m = 1'b1; tick(2*Q);
        scl_m = 1'b0; tick(Q);
        sda_m = 1'b1;
    endtask

    task automatic model_write(input logic [7:0] sub, input int n);
        int p = int'(sub);
        for (int k = 0; k < n; k++) begin
            if (p < NR) exp_r[p] = wbuf[k];
            if (p < NR - 1) p++;
        end
    endtask

    task automatic wr_burst(input logic [7:0] sub, input int n);
        bit ack;
        bit all_ack = 1'b1;
        bus_start();
        put_byte(8'h8A, ack);
        check(ack, "R1 write address acknowledged", {159'b0, ack}, 160'd1);
        put_byte(sub, ack);
        all_ack &= ack;
        for (int k = 0; k < n; k++) begin
            put_byte(wbuf[k], ack);
            all_ack &= ack;
        end
        check(all_ack, "R2 index and data acknowledged", {159'b0, all_ack}, 160'd1);
        bus_stop();
        tick(4);
        model_write(sub, n);
    endtask

    task automatic rd_status(input int n);
        bit ack;
        bus_start();
        put_byte(8'h8B, ack);
        check(ack, "R1 read address acknowledged", {159'b0, ack}, 160'd1);
        for (int k = 0; k < n; k++) get_byte(k == n - 1, rbuf[k]);
        bus_stop();
        tick(4);
    endtask

    function automatic logic [159:0] exp_vec();
        logic [159:0] v = '0;
        for (int k = 0; k < NR; k++) v[8*k +: 8] = exp_r[k];
        return v;
    endfunction

    task automatic compare_all(input string tag);
        logic [159:0] e = exp_vec();
        check(ctrl_regs_o == e, tag, ctrl_regs_o, e);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            finish_run();
        end
    end

    initial begin
        bit ack;
        logic [7:0] b;
        for (int k = 0; k < NR; k++) exp_r[k] = 8'h00;
        tick(6);
        rst = 1'b0;
        tick(6);

        // R8 reset state
        check(ctrl_regs_o == '0, "R8 registers zero after reset", ctrl_regs_o, 160'd0);
        check(sda_oe == 1'b0, "R8 sda released after reset", {159'b0, sda_oe}, 160'd0);
        check(all_written_o == 1'b0, "R8 ready flag low after reset", {159'b0, all_written_o}, 160'd0);

        // R7 full burst while POR still set does not raise the flag
        for (int k = 0; k < NR; k++) wbuf[k] = 8'hA0 + 8'(k);
        wr_burst(8'h00, NR);
        compare_all("R2 burst before POR poll stored");
        check(all_written_o == 1'b0, "R7 no ready flag while POR set", {159'b0, all_written_o}, 160'd0);

        // R5 R6 first status read
        no_defl_i = 1'b1; if_ident_i = 1'b0;
        rd_status(3);
        check(rbuf[0] == 8'h80, "R6 POR set after reset", {152'b0, rbuf[0]}, 160'h80);
        check(rbuf[1] == 8'h80, "R5 second byte no-deflection bit", {152'b0, rbuf[1]}, 160'h80);
        check(rbuf[2] == 8'h00, "R5 third byte zero", {152'b0, rbuf[2]}, 160'h00);
        no_defl_i = 1'b0; if_ident_i = 1'b1;
        rd_status(2);
        check(rbuf[0] == 8'h00, "R6 POR cleared after shift out", {152'b0, rbuf[0]}, 160'h00);
        check(rbuf[1] == 8'h10, "R5 second byte IF-ident bit", {152'b0, rbuf[1]}, 160'h10);

        // Vector table: R2 R3 R4
        for (int v = 0; v < 6; v++) begin
            wbuf[0] = VEC[v].d0;
            wbuf[1] = VEC[v].d1;
            wbuf[2] = VEC[v].d2;
            snap = ctrl_regs_o;
            wr_burst(VEC[v].sub, int'(VEC[v].n));
            if (VEC[v].keep)
                check(ctrl_regs_o == snap, "R4 out-of-range data discarded", ctrl_regs_o, snap);
            else
                check(ctrl_regs_o[8*VEC[v].csub +: 8] == VEC[v].cval, "R3 auto-increment target",
                      {152'b0, ctrl_regs_o[8*VEC[v].csub +: 8]}, {152'b0, VEC[v].cval});
            compare_all("R2 register image after burst");
        end
        check(ctrl_regs_o[8*8'h12 +: 8] == 8'h41, "R3 index 0x12 kept separate from 0x13",
              {152'b0, ctrl_regs_o[8*8'h12 +: 8]}, 160'h41);

        // R1 foreign address
        snap = ctrl_regs_o;
        bus_start();
        put_byte(8'h8C, ack);
        check(!ack, "R1 foreign address not acknowledged", {159'b0, ack}, 160'd0);
        put_byte(8'h00, ack);
        put_byte(8'hEE, ack);
        bus_stop();
        tick(4);
        check(ctrl_regs_o == snap, "R1 foreign transfer leaves registers", ctrl_regs_o, snap);

        // R7 full write after POR cleared raises flag
        for (int k = 0; k < NR; k++) wbuf[k] = 8'h3 * 8'(k) + 8'h1;
        wr_burst(8'h00, NR);
        compare_all("R2 full burst stored");
        check(all_written_o == 1'b1, "R7 ready flag after all registers", {159'b0, all_written_o}, 160'd1);

        // R10 repeated start: write then read in one transfer
        bus_start();
        put_byte(8'h8A, ack);
        put_byte(8'h03, ack);
        put_byte(8'h77, ack);
        bus_start();
        put_byte(8'h8B, ack);
        check(ack, "R10 address after repeated start acknowledged", {159'b0, ack}, 160'd1);
        get_byte(1'b1, b);
        bus_stop();
        tick(4);
        exp_r[3] = 8'h77;
        check(b == 8'h00, "R10 status after repeated start", {152'b0, b}, 160'h00);
        compare_all("R10 data before repeated start kept");

        // R6 R7 supply dip
        brownout = 1'b1; tick(1); brownout = 1'b0; tick(2);
        check(all_written_o == 1'b0, "R7 ready flag cleared by POR", {159'b0, all_written_o}, 160'd0);

        // R6 dip overlapping the byte that would clear POR
        bus_start();
        put_byte(8'h8B, ack);
        brownout = 1'b1;
        get_byte(1'b1, b);
        brownout = 1'b0;
        bus_stop();
        tick(4);
        check(b == 8'h80, "R6 POR visible during overlapped read", {152'b0, b}, 160'h80);
        rd_status(1);
        check(rbuf[0] == 8'h80, "R6 dip wins over clear", {152'b0, rbuf[0]}, 160'h80);
        rd_status(1);
        check(rbuf[0] == 8'h00, "R6 POR cleared by later read", {152'b0, rbuf[0]}, 160'h00);
        check(all_written_o == 1'b0, "R7 old writes not counted after dip", {159'b0, all_written_o}, 160'd0);
        compare_all("R6 registers survive supply dip");

        finish_run();
    end

endmodule